// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds the time of day and the calendar as seven packed-BCD bytes: seconds, minutes, hours, weekday, date, month with a century flag, and a two-digit year. Each cycle in which the one-second enable is high moves the time forward by one second. Carries ripple through minutes, hours, weekday, date, month and year. Month lengths follow the calendar, and February has a 29th day in every year that is a multiple of four. The hours byte carries its own format bit, so one field selects either a 24-hour count or a 12-hour count with a PM indicator.

Host logic loads any field through a one-byte write port. A write wins over the one-second step for the field it targets.

Reads come from a separate snapshot. A capture strobe copies all seven counting bytes into holding registers in one cycle. The snapshot outputs then stay fixed while the counters run on, so a host reading field by field always sees one consistent instant.

Top module: `cal_bcd_counter`

## Requirements
- R1: With `wr_en` high, `wr_data` is loaded into the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. The new value holds from the next cycle on. A write with `wr_sel` = 7 changes no field.
- R2: In a cycle with neither `tick_1hz` nor `wr_en` high, no counting field changes.
- R3: Seconds and minutes count in packed BCD from 00 to 59. The step from 59 wraps to 00 and carries into the next field.
- R4: With hours bit 6 at 0 (24-hour format), hours count 00 to 23. Bits 5:4 hold the tens digit and bits 3:0 the units digit. The step from 23:59:59 gives 00:00:00 and ends the day.
- R5: The weekday (bits 2:0 in use) advances once at each end of day and wraps from 7 to 1.
- R6: At the end of day the date moves on, wrapping to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year value is divisible by 4 (year 00 included) and 28 days otherwise. All other months have 31 days. Wrapping month 12 gives month 01 and advances the year.
- R7: Month bits 4:0 hold the BCD month and bit 7 is the century flag. The century flag inverts each time the year steps from 99 to 00.
- R8: With hours bit 6 at 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold the BCD hour. The hour runs 12, 01, …, 11, 12. PM inverts only on the step from 11 to 12. The day ends on the step from 11:59:59 PM to 12:00:00 AM.
- R9: After reset both the counters and the snapshot read 00:00:00 (hours byte 00), weekday 01, date 01, month 01, year 00.
- R10: When a write and a tick share a cycle, the written field takes `wr_data`. Every other field advances exactly as the tick alone would make it, and any carry into the written field is dropped.
- R11: Bits outside each field read 0 after a write. The masks are seconds 7F, minutes 7F, hours 7F, weekday 07, date 3F, month 9F and year FF (hex).
- R12: A cycle with `snap` high copies the counter values present before that cycle's update into the snapshot outputs. The copy is visible from the next cycle, and the outputs do not change between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Field write enable |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Packed-BCD value to load |
| snap | input | 1 | Capture strobe for the snapshot |
| snap_sec | output | 8 | Snapshot seconds |
| snap_min | output | 8 | Snapshot minutes |
| snap_hour | output | 8 | Snapshot hours with format and PM bits |
| snap_wday | output | 8 | Snapshot weekday |
| snap_date | output | 8 | Snapshot date |
| snap_month | output | 8 | Snapshot month with century flag |
| snap_year | output | 8 | Snapshot year |

## Verification
The bench targets the calendar boundaries first.
- A 30-day month end: a design that treats every month as 31 days would show date 31 instead of wrapping.
- February in a leap year, a common year and year 00: a design that gets the leap test wrong lands on March 1 too early or a day late.
- 99 to 00 with the century flag set and clear: a design that sets the flag instead of inverting it leaves it stuck at 1.

In 12-hour format the bench walks 11 to 12, 12 to 1 and 11 PM to midnight. A wrong PM toggle point flips AM/PM an hour off or never advances the date.

The bench also places a write and a tick in the same cycle, aimed once at the carry source and once at the carry target. It strobes the capture on a tick cycle. Then it ticks without strobing. A design that lets the tick overwrite the write, or that passes live counters through to the snapshot, shows a value one second off.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 3;

    typedef logic [BYTE_W-1:0] bcd_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_WDAY  = 3'd3,
        SEL_DATE  = 3'd4,
        SEL_MONTH = 3'd5,
        SEL_YEAR  = 3'd6,
        SEL_NONE  = 3'd7
    } field_sel_e;

    typedef struct packed {
        bcd_t sec;
        bcd_t min;
        bcd_t hour;
        bcd_t wday;
        bcd_t date;
        bcd_t month;
        bcd_t year;
    } cal_time_t;

    localparam bcd_t MASK_SEC   = 8'h7F;
    localparam bcd_t MASK_MIN   = 8'h7F;
    localparam bcd_t MASK_HOUR  = 8'h7F;
    localparam bcd_t MASK_WDAY  = 8'h07;
    localparam bcd_t MASK_DATE  = 8'h3F;
    localparam bcd_t MASK_MONTH = 8'h9F;
    localparam bcd_t MASK_YEAR  = 8'hFF;

    localparam cal_time_t RESET_TIME = '{
        sec:   8'h00,
        min:   8'h00,
        hour:  8'h00,
        wday:  8'h01,
        date:  8'h01,
        month: 8'h01,
        year:  8'h00
    };

    // Two-digit BCD increment; the caller handles the wrap.
    function automatic bcd_t bcd_inc(input bcd_t v);
        if (v[3:0] == 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input bcd_t v);
        return ({4'b0000, v[7:4]} * 8'd10) + {4'b0000, v[3:0]};
    endfunction

    function automatic logic year_is_leap(input bcd_t yr);
        logic [7:0] b;
        b = bcd_to_bin(yr);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic bcd_t month_last_day(input logic [4:0] mon, input logic leap);
        case (mon)
            5'h02:                      return leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_tod_step.sv
`timescale 1ns/1ps
// Next-second values for seconds, minutes and hours, plus the end-of-day carry.
module cal_tod_step
    import cal_pkg::*;
(
    input  bcd_t       sec_in,
    input  bcd_t       min_in,
    input  logic [6:0] hour_in,
    output bcd_t       sec_nx,
    output bcd_t       min_nx,
    output bcd_t       hour_nx,
    output logic       day_end
);

    logic       sec_wrap;
    logic       min_wrap;
    logic [6:0] hour_adv;
    logic       hour_last;

    always_comb begin
        sec_wrap = (sec_in == 8'h59);
        min_wrap = sec_wrap && (min_in == 8'h59);

        sec_nx = sec_wrap ? 8'h00 : bcd_inc(sec_in);
        if (!sec_wrap) begin
            min_nx = min_in;
        end else begin
            min_nx = min_wrap ? 8'h00 : bcd_inc(min_in);
        end

        hour_adv  = hour_in;
        hour_last = 1'b0;
        if (hour_in[6]) begin
            // 12-hour format: bit 5 is PM, bits 4:0 are the hour
            if (hour_in[4:0] == 5'h12) begin
                hour_adv = {1'b1, hour_in[5], 5'h01};
            end else if (hour_in[4:0] == 5'h11) begin
                hour_adv  = {1'b1, ~hour_in[5], 5'h12};
                hour_last = hour_in[5];
            end else if (hour_in[3:0] == 4'd9) begin
                hour_adv = {1'b1, hour_in[5], 5'h10};
            end else begin
                hour_adv = {1'b1, hour_in[5], hour_in[4], hour_in[3:0] + 4'd1};
            end
        end else begin
            // 24-hour format: bits 5:4 tens, bits 3:0 units
            if (hour_in[5:0] == 6'h23) begin
                hour_adv  = 7'h00;
                hour_last = 1'b1;
            end else if (hour_in[3:0] == 4'd9) begin
                hour_adv = {1'b0, hour_in[5:4] + 2'd1, 4'd0};
            end else begin
                hour_adv = {1'b0, hour_in[5:4], hour_in[3:0] + 4'd1};
            end
        end

        hour_nx = min_wrap ? {1'b0, hour_adv} : {1'b0, hour_in};
        day_end = min_wrap && hour_last;
    end

endmodule

// File: rtl/cal_date_step.sv
`timescale 1ns/1ps
// Calendar advance on an end-of-day carry: weekday, date, month, century, year.
module cal_date_step
    import cal_pkg::*;
(
    input  logic       day_end,
    input  bcd_t       wday_in,
    input  bcd_t       date_in,
    input  logic       cent_in,
    input  logic [4:0] mon_in,
    input  bcd_t       year_in,
    output bcd_t       wday_nx,
    output bcd_t       date_nx,
    output bcd_t       month_nx,
    output bcd_t       year_nx
);

    bcd_t last_day;
    logic month_end;
    logic year_end;
    logic cent_flip;
    bcd_t mon_inc;

    always_comb begin
        last_day  = month_last_day(mon_in, year_is_leap(year_in));
        month_end = (date_in == last_day);
        year_end  = month_end && (mon_in == 5'h12);
        cent_flip = year_end && (year_in == 8'h99);
        mon_inc   = bcd_inc({3'b000, mon_in});

        wday_nx  = wday_in;
        date_nx  = date_in;
        month_nx = {cent_in, 2'b00, mon_in};
        year_nx  = year_in;

        if (day_end) begin
            wday_nx = (wday_in == 8'h07) ? 8'h01 : wday_in + 8'd1;
            date_nx = month_end ? 8'h01 : bcd_inc(date_in);
            if (year_end) begin
                month_nx = {cent_in ^ cent_flip, 2'b00, 5'h01};
                year_nx  = (year_in == 8'h99) ? 8'h00 : bcd_inc(year_in);
            end else if (month_end) begin
                month_nx = {cent_in, 2'b00, mon_inc[4:0]};
            end
        end
    end

    logic unused_mon_inc;
    assign unused_mon_inc = ^mon_inc[7:5];

endmodule

// File: rtl/cal_shadow.sv
`timescale 1ns/1ps
// Holding copy of the counters, loaded only on the capture strobe.
module cal_shadow
    import cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture,
    input  cal_time_t live,
    output cal_time_t held
);

    cal_time_t held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (capture) begin
            held_d = live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= RESET_TIME;
        end else begin
            held_q <= held_d;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/cal_bcd_counter.sv
`timescale 1ns/1ps
module cal_bcd_counter
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              snap,
    output logic [BYTE_W-1:0] snap_sec,
    output logic [BYTE_W-1:0] snap_min,
    output logic [BYTE_W-1:0] snap_hour,
    output logic [BYTE_W-1:0] snap_wday,
    output logic [BYTE_W-1:0] snap_date,
    output logic [BYTE_W-1:0] snap_month,
    output logic [BYTE_W-1:0] snap_year
);

    cal_time_t cnt_d, cnt_q;
    cal_time_t stepped;
    cal_time_t held;
    logic      day_end;

    cal_tod_step u_tod (
        .sec_in  (cnt_q.sec),
        .min_in  (cnt_q.min),
        .hour_in (cnt_q.hour[6:0]),
        .sec_nx  (stepped.sec),
        .min_nx  (stepped.min),
        .hour_nx (stepped.hour),
        .day_end (day_end)
    );

    cal_date_step u_date (
        .day_end  (day_end),
        .wday_in  (cnt_q.wday),
        .date_in  (cnt_q.date),
        .cent_in  (cnt_q.month[7]),
        .mon_in   (cnt_q.month[4:0]),
        .year_in  (cnt_q.year),
        .wday_nx  (stepped.wday),
        .date_nx  (stepped.date),
        .month_nx (stepped.month),
        .year_nx  (stepped.year)
    );

    // Tick first, then the host write overrides its own field only.
    always_comb begin
        cnt_d = cnt_q;
        if (tick_1hz) begin
            cnt_d = stepped;
        end
        if (wr_en) begin
            case (wr_sel)
                SEL_SEC:   cnt_d.sec   = wr_data & MASK_SEC;
                SEL_MIN:   cnt_d.min   = wr_data & MASK_MIN;
                SEL_HOUR:  cnt_d.hour  = wr_data & MASK_HOUR;
                SEL_WDAY:  cnt_d.wday  = wr_data & MASK_WDAY;
                SEL_DATE:  cnt_d.date  = wr_data & MASK_DATE;
                SEL_MONTH: cnt_d.month = wr_data & MASK_MONTH;
                SEL_YEAR:  cnt_d.year  = wr_data & MASK_YEAR;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_TIME;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    cal_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (snap),
        .live    (cnt_q),
        .held    (held)
    );

    assign snap_sec   = held.sec;
    assign snap_min   = held.min;
    assign snap_hour  = held.hour;
    assign snap_wday  = held.wday;
    assign snap_date  = held.date;
    assign snap_month = held.month;
    assign snap_year  = held.year;

endmodule

// File: rtl/cal_bcd_counter_chk.sv
`timescale 1ns/1ps
module cal_bcd_counter_chk
    import cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick_1hz,
    input logic      wr_en,
    input logic      snap,
    input cal_time_t cur,
    input cal_time_t held
);

    // R2: idle cycles leave every counter untouched
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !wr_en) |=> $stable(cur));

    // R3: seconds wrap from 59 to 00 on a tick
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wr_en && cur.sec == 8'h59) |=> (cur.sec == 8'h00));

    // R5: weekday 7 wraps to 1 at 24-hour midnight
    a_r5_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_1hz && !wr_en && cur.wday == 8'h07 && cur.hour == 8'h23 &&
         cur.min == 8'h59 && cur.sec == 8'h59) |=> (cur.wday == 8'h01));

    // R7: century flag only inverts on the year step 99 -> 00
    a_r7_century_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && (cur.month[7] != $past(cur.month[7]))) |->
        ($past(cur.year) == 8'h99 && cur.year == 8'h00));

    // R8: PM only inverts on the 12-hour step 11 -> 12
    a_r8_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(cur.hour[6]) && (cur.hour[5] != $past(cur.hour[5]))) |->
        (cur.hour[4:0] == 5'h12 && $past(cur.hour[4:0]) == 5'h11));

    // R12: capture copies the pre-update counters
    a_r12_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (held == $past(cur)));

    // R12: snapshot holds between strobes
    a_r12_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(held));

endmodule

bind cal_bcd_counter cal_bcd_counter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .wr_en    (wr_en),
    .snap     (snap),
    .cur      (cnt_q),
    .held     (held)
);

// File: tb/cal_bcd_counter_test.sv
`timescale 1ns/1ps
module cal_bcd_counter_test;

    localparam logic [2:0] F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2, F_WDAY = 3'd3,
                           F_DATE = 3'd4, F_MON = 3'd5, F_YEAR = 3'd6, F_NONE = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       snap = 1'b0;
    logic [7:0] snap_sec, snap_min, snap_hour, snap_wday, snap_date, snap_month, snap_year;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [55:0] exp_q[$];
    string       tag_q[$];
    logic        snap_dly = 1'b0;

    always #2.5 clk = ~clk;

    cal_bcd_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .snap(snap),
        .snap_sec(snap_sec), .snap_min(snap_min), .snap_hour(snap_hour),
        .snap_wday(snap_wday), .snap_date(snap_date), .snap_month(snap_month),
        .snap_year(snap_year)
    );

    function automatic logic [55:0] pk(input logic [7:0] s, m, h, w, d, mo, y);
        return {s, m, h, w, d, mo, y};
    endfunction

    function automatic logic [55:0] outs();
        return {snap_sec, snap_min, snap_hour, snap_wday, snap_date, snap_month, snap_year};
    endfunction

    task automatic compare(input logic [55:0] got, input logic [55:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic t, input logic we, input logic [2:0] sel,
                         input logic [7:0] d, input logic s);
        @(negedge clk);
        tick_1hz = t; wr_en = we; wr_sel = sel; wr_data = d; snap = s;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        drive(1'b0, 1'b1, sel, d, 1'b0);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y);
        wr(F_SEC, s); wr(F_MIN, m); wr(F_HOUR, h); wr(F_WDAY, w);
        wr(F_DATE, d); wr(F_MON, mo); wr(F_YEAR, y);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 8'h00, 1'b0);
    endtask

    // Driver: push the expected snapshot, then strobe the capture
    task automatic capture(input logic [55:0] exp, input string tag, input logic with_tick = 1'b0);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(with_tick, 1'b0, 3'd0, 8'h00, 1'b1);
        idle();
    endtask

    // Monitor: compare one queued item per strobe, one cycle after it
    always @(posedge clk) snap_dly <= snap;

    initial begin
        forever begin
            @(negedge clk);
            if (snap_dly) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R12 unexpected capture got=%h exp=none", outs());
                end else begin
                    compare(outs(), exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(outs(), pk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), "R9 snapshot in reset");
        rst_n = 1'b1;
        idle();
        capture(pk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00), "R9 counters after reset");

        // R1 R3: second and minute carry into hour
        set_time(8'h58, 8'h59, 8'h09, 8'h03, 8'h15, 8'h06, 8'h23);
        ticks(2);
        capture(pk(8'h00,8'h00,8'h10,8'h03,8'h15,8'h06,8'h23), "R3 carry 09:59:58+2");

        // R4 R5 R6: midnight at end of a 30-day month, weekday 7 -> 1
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h04, 8'h24);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h01,8'h01,8'h05,8'h24), "R4 R5 R6 end of April");

        // R6: February in leap and common years
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24), "R6 leap Feb 28");
        wr(F_SEC, 8'h59); wr(F_MIN, 8'h59); wr(F_HOUR, 8'h23);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h24), "R6 leap Feb 29");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h23);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h06,8'h01,8'h03,8'h23), "R6 common Feb 28");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h00), "R6 year 00 leap");

        // R7: century flag inverts both ways
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h07,8'h01,8'h81,8'h00), "R7 century set");
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h92, 8'h99);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h00,8'h07,8'h01,8'h01,8'h00), "R7 century clear");

        // R8: 12-hour format transitions
        set_time(8'h59, 8'h59, 8'h51, 8'h02, 8'h10, 8'h03, 8'h21);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h72,8'h02,8'h10,8'h03,8'h21), "R8 11AM to 12PM");
        wr(F_SEC, 8'h59); wr(F_MIN, 8'h59);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h61,8'h02,8'h10,8'h03,8'h21), "R8 12PM to 1PM");
        wr(F_SEC, 8'h59); wr(F_MIN, 8'h59); wr(F_HOUR, 8'h71);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h52,8'h03,8'h11,8'h03,8'h21), "R8 11PM to 12AM");
        wr(F_SEC, 8'h59); wr(F_MIN, 8'h59);
        ticks(1);
        capture(pk(8'h00,8'h00,8'h41,8'h03,8'h11,8'h03,8'h21), "R8 12AM to 1AM");

        // R10: write and tick in the same cycle
        set_time(8'h59, 8'h10, 8'h08, 8'h02, 8'h10, 8'h03, 8'h21);
        drive(1'b1, 1'b1, F_SEC, 8'h30, 1'b0);
        idle();
        capture(pk(8'h30,8'h11,8'h08,8'h02,8'h10,8'h03,8'h21), "R10 write sec with tick");
        wr(F_SEC, 8'h59);
        drive(1'b1, 1'b1, F_MIN, 8'h05, 1'b0);
        idle();
        capture(pk(8'h00,8'h05,8'h08,8'h02,8'h10,8'h03,8'h21), "R10 write min with tick");

        // R11: unused bits cleared on write
        set_time(8'hA5, 8'h93, 8'h85, 8'hF4, 8'hD7, 8'h69, 8'h42);
        capture(pk(8'h25,8'h13,8'h05,8'h04,8'h17,8'h09,8'h42), "R11 field masks");

        // R2 R1: idle cycles and select 7 change nothing
        repeat (10) idle();
        wr(F_NONE, 8'h55);
        idle();
        capture(pk(8'h25,8'h13,8'h05,8'h04,8'h17,8'h09,8'h42), "R2 R1 idle and select 7");

        // R12: capture on a tick cycle, then hold while counting
        capture(pk(8'h25,8'h13,8'h05,8'h04,8'h17,8'h09,8'h42), "R12 capture with tick", 1'b1);
        capture(pk(8'h26,8'h13,8'h05,8'h04,8'h17,8'h09,8'h42), "R12 after tick");
        ticks(5);
        idle();
        compare(outs(), pk(8'h26,8'h13,8'h05,8'h04,8'h17,8'h09,8'h42), "R12 hold while counting");
        capture(pk(8'h31,8'h13,8'h05,8'h04,8'h17,8'h09,8'h42), "R12 fresh capture");

        repeat (3) idle();
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R12 pending=%0d exp=0", exp_q.size());
        end
        finish_run();
    end

endmodule